// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a display panel up and down in a fixed order. It drives the panel's supply switch, its enable line, its reset line and the backlight enable. It also starts an external command-stream engine and waits for it to finish. Four one-cycle requests drive it: prepare, unprepare, enable and disable. Prepare and unprepare move the panel between unpowered and powered-and-initialised. Enable and disable switch the backlight on the powered panel. Each step of a sequence can be followed by a programmable wait, counted in pulses of a millisecond tick.

Two internal flags, prepared and enabled, gate the requests, so a request that would repeat the current condition does nothing. Only one sequence runs at a time, and `busy` shows that one is in progress. The supply output can be inverted for supply switches that are active low.

States and transitions (S_ marks a state; "N" is the delay of a wait state; a zero delay skips its wait state):

| State | Action on entry | Leaves to |
|---|---|---|
| S_IDLE | none | S_BL_OFF, S_OFF_CMD, S_PWR_UP, S_EN_WAIT or S_BL_ON on an accepted request |
| S_PWR_UP | supply on, panel enable high | S_PREP_WAIT, or S_RST_HI if N=0 |
| S_PREP_WAIT | load prepare delay | S_RST_HI on the last tick |
| S_RST_HI | reset high | S_RST_WAIT, or S_RST_LO if N=0 |
| S_RST_WAIT | load reset delay | S_RST_LO on the last tick |
| S_RST_LO | reset low | S_INIT_WAIT, or S_ON_CMD if N=0 |
| S_INIT_WAIT | load init delay | S_ON_CMD on the last tick |
| S_ON_CMD | start pulse, stream select = power-on | S_ON_WAIT |
| S_ON_WAIT | none | S_IDLE on done; prepared set |
| S_OFF_CMD | start pulse, stream select = power-off | S_OFF_WAIT |
| S_OFF_WAIT | none | S_PWR_DN on done |
| S_PWR_DN | reset high, panel enable low, supply off | S_UNPREP_WAIT, or S_IDLE if N=0; prepared cleared on reaching S_IDLE |
| S_UNPREP_WAIT | load unprepare delay | S_IDLE on the last tick |
| S_EN_WAIT | load enable delay | S_BL_ON on the last tick |
| S_BL_ON | backlight on | S_IDLE; enabled set |
| S_BL_OFF | backlight off | S_DIS_WAIT, or S_IDLE if N=0 |
| S_DIS_WAIT | load disable delay | S_IDLE on the last tick; enabled cleared |

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `supply_en` equals `supply_invert` (supply off), `panel_en`, `panel_rst`, `bl_en`, `cmd_start` and `busy` are 0, and both flags are clear.
- R2: An accepted prepare raises `busy`, `panel_en` and the supply on one clock edge. With a tick every cycle, `panel_rst` rises 1+Dp cycles later (Dp = `dly_prepare`).
- R3: `panel_rst` falls 2+Dp+Dr cycles after `panel_en` rises (Dr = `dly_reset`). `cmd_start` pulses 1+Di cycles after that fall (Di = `dly_init`), with `cmd_sel` = 0 (power-on stream).
- R4: Prepare ends when `cmd_done` is sampled high after the start pulse. `busy` falls on the next edge and the prepared flag is set.
- R5: An accepted unprepare pulses `cmd_start` with `cmd_sel` = 1 on the edge where `busy` rises, and leaves the supply and `panel_en` unchanged. On the edge after `cmd_done` is sampled, `panel_rst` goes high, `panel_en` low and the supply off, all together. `busy` falls 1+Du cycles after that (Du = `dly_unprepare`).
- R6: An accepted enable raises `bl_en` De cycles after `busy` rises (De = `dly_enable`), and `busy` falls one cycle later. An accepted disable drops `bl_en` on the edge where `busy` rises, and `busy` falls 1+Dd cycles later (Dd = `dly_disable`).
- R7: Prepare is ignored when the panel is already prepared, and unprepare when it is not. Enable is ignored when enabled, and disable when not enabled. An ignored request leaves `busy` low and all outputs unchanged.
- R8: A delay of zero skips its wait state. The sequence then goes straight to the next step, as the cycle counts in R2, R3, R5 and R6 with D=0 show.
- R9: Requests that arrive while `busy` is high are dropped, not stored.
- R10: `supply_en` is the logical supply state XOR `supply_invert`.
- R11: Wait states count `ms_tick` pulses, not clock cycles. While `ms_tick` is low, a wait state holds.
- R12: When several eligible requests arrive in the same idle cycle, only one runs, in the priority disable, unprepare, prepare, enable. The others are dropped.
- R13: `cmd_start` is a single-cycle pulse, raised only in S_ON_CMD or S_OFF_CMD. A `cmd_done` outside the two completion-wait states has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_prepare | input | 1 | Prepare request pulse |
| req_unprepare | input | 1 | Unprepare request pulse |
| req_enable | input | 1 | Enable request pulse |
| req_disable | input | 1 | Disable request pulse |
| dly_prepare | input | DLY_W | Ticks after supply and panel enable |
| dly_reset | input | DLY_W | Ticks reset is held high |
| dly_init | input | DLY_W | Ticks between reset release and the power-on stream |
| dly_unprepare | input | DLY_W | Ticks after power removal |
| dly_enable | input | DLY_W | Ticks before backlight on |
| dly_disable | input | DLY_W | Ticks after backlight off |
| supply_invert | input | 1 | Inverts the supply output polarity |
| ms_tick | input | 1 | One-cycle millisecond tick |
| cmd_done | input | 1 | Command-stream engine finished |
| supply_en | output | 1 | Supply switch control |
| panel_en | output | 1 | Panel enable line |
| panel_rst | output | 1 | Panel reset line |
| bl_en | output | 1 | Backlight enable |
| cmd_start | output | 1 | Start pulse for the command-stream engine |
| cmd_sel | output | 1 | Stream select: 0 power-on, 1 power-off |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench stamps every output edge and compares the gaps against the delay formulas. A swapped delay input or an off-by-one wait count then shows up as a wrong gap, not only as a wrong final level. It repeats each request to confirm that the flags block it, and runs an all-zero-delay pass to catch a wait state that loads zero and would count 2^DLY_W ticks instead of skipping. It holds the tick low mid-sequence, which exposes a timer that counts clocks. It sends an enable during a prepare: a design that stored the request would light the backlight afterwards. It also sends disable and unprepare together: a design with the wrong priority would remove power while the backlight is still on.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PWR_UP,
        S_PREP_WAIT,
        S_RST_HI,
        S_RST_WAIT,
        S_RST_LO,
        S_INIT_WAIT,
        S_ON_CMD,
        S_ON_WAIT,
        S_OFF_CMD,
        S_OFF_WAIT,
        S_PWR_DN,
        S_UNPREP_WAIT,
        S_EN_WAIT,
        S_BL_ON,
        S_BL_OFF,
        S_DIS_WAIT
    } pps_state_e;

    localparam logic SEL_ON  = 1'b0;
    localparam logic SEL_OFF = 1'b1;

    function automatic logic is_wait(pps_state_e s);
        return (s == S_PREP_WAIT)   || (s == S_RST_WAIT) || (s == S_INIT_WAIT) ||
               (s == S_UNPREP_WAIT) || (s == S_EN_WAIT)  || (s == S_DIS_WAIT);
    endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = tick && (cnt == ONE);

    AST_TMR_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt)); // R11

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (cnt == '0)) |=> (cnt == '0)); // R11

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
    import pps_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_prepare,
    input  logic             req_unprepare,
    input  logic             req_enable,
    input  logic             req_disable,
    input  logic [DLY_W-1:0] dly_prepare,
    input  logic [DLY_W-1:0] dly_reset,
    input  logic [DLY_W-1:0] dly_init,
    input  logic [DLY_W-1:0] dly_unprepare,
    input  logic [DLY_W-1:0] dly_enable,
    input  logic [DLY_W-1:0] dly_disable,
    input  logic             tmr_last,
    input  logic             cmd_done,
    output pps_state_e       state_q,
    output pps_state_e       state_d,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val,
    output logic             busy
);

    logic prepared;
    logic enabled;
    logic dis_ok, unp_ok, prp_ok, ena_ok;
    logic entering;

    assign dis_ok   = req_disable   &&  enabled;
    assign unp_ok   = req_unprepare &&  prepared;
    assign prp_ok   = req_prepare   && !prepared;
    assign ena_ok   = req_enable    && !enabled;
    assign entering = (state_d != state_q);
    assign busy     = (state_q != S_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (dis_ok)      state_d = S_BL_OFF;
                else if (unp_ok) state_d = S_OFF_CMD;
                else if (prp_ok) state_d = S_PWR_UP;
                else if (ena_ok) state_d = (dly_enable != '0) ? S_EN_WAIT : S_BL_ON;
            end
            S_PWR_UP:      state_d = (dly_prepare != '0) ? S_PREP_WAIT : S_RST_HI;
            S_PREP_WAIT:   if (tmr_last) state_d = S_RST_HI;
            S_RST_HI:      state_d = (dly_reset != '0) ? S_RST_WAIT : S_RST_LO;
            S_RST_WAIT:    if (tmr_last) state_d = S_RST_LO;
            S_RST_LO:      state_d = (dly_init != '0) ? S_INIT_WAIT : S_ON_CMD;
            S_INIT_WAIT:   if (tmr_last) state_d = S_ON_CMD;
            S_ON_CMD:      state_d = S_ON_WAIT;
            S_ON_WAIT:     if (cmd_done) state_d = S_IDLE;
            S_OFF_CMD:     state_d = S_OFF_WAIT;
            S_OFF_WAIT:    if (cmd_done) state_d = S_PWR_DN;
            S_PWR_DN:      state_d = (dly_unprepare != '0) ? S_UNPREP_WAIT : S_IDLE;
            S_UNPREP_WAIT: if (tmr_last) state_d = S_IDLE;
            S_EN_WAIT:     if (tmr_last) state_d = S_BL_ON;
            S_BL_ON:       state_d = S_IDLE;
            S_BL_OFF:      state_d = (dly_disable != '0) ? S_DIS_WAIT : S_IDLE;
            S_DIS_WAIT:    if (tmr_last) state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            S_PREP_WAIT:   tmr_val = dly_prepare;
            S_RST_WAIT:    tmr_val = dly_reset;
            S_INIT_WAIT:   tmr_val = dly_init;
            S_UNPREP_WAIT: tmr_val = dly_unprepare;
            S_EN_WAIT:     tmr_val = dly_enable;
            S_DIS_WAIT:    tmr_val = dly_disable;
            default:       tmr_val = '0;
        endcase
    end

    assign tmr_load = entering && is_wait(state_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            prepared <= 1'b0;
            enabled  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (entering && (state_d == S_IDLE)) begin
                unique case (state_q)
                    S_ON_WAIT:                 prepared <= 1'b1;
                    S_PWR_DN, S_UNPREP_WAIT:   prepared <= 1'b0;
                    S_BL_ON:                   enabled  <= 1'b1;
                    S_BL_OFF, S_DIS_WAIT:      enabled  <= 1'b0;
                    default:                   ;
                endcase
            end
        end
    end

    AST_PREP_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prepared) |-> $past(cmd_done)); // R4

    AST_PWR_UP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PWR_UP) |-> ($past(state_q) == S_IDLE)); // R9

    AST_OFF_CMD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF_CMD) |-> ($past(state_q) == S_IDLE)); // R9

    AST_NO_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> (tmr_val != '0)); // R8

endmodule

// File: rtl/pps_drive.sv
module pps_drive
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pps_state_e state_q,
    input  pps_state_e state_d,
    output logic       supply_on,
    output logic       panel_en,
    output logic       panel_rst,
    output logic       bl_en,
    output logic       cmd_start,
    output logic       cmd_sel
);

    logic entering;
    assign entering = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            supply_on <= 1'b0;
            panel_en  <= 1'b0;
            panel_rst <= 1'b0;
            bl_en     <= 1'b0;
            cmd_start <= 1'b0;
            cmd_sel   <= SEL_ON;
        end else begin
            cmd_start <= 1'b0;
            if (entering) begin
                unique case (state_d)
                    S_PWR_UP: begin
                        supply_on <= 1'b1;
                        panel_en  <= 1'b1;
                    end
                    S_RST_HI:  panel_rst <= 1'b1;
                    S_RST_LO:  panel_rst <= 1'b0;
                    S_ON_CMD: begin
                        cmd_start <= 1'b1;
                        cmd_sel   <= SEL_ON;
                    end
                    S_OFF_CMD: begin
                        cmd_start <= 1'b1;
                        cmd_sel   <= SEL_OFF;
                    end
                    S_PWR_DN: begin
                        panel_rst <= 1'b1;
                        panel_en  <= 1'b0;
                        supply_on <= 1'b0;
                    end
                    S_BL_ON:   bl_en <= 1'b1;
                    S_BL_OFF:  bl_en <= 1'b0;
                    default:   ;
                endcase
            end
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R13

    AST_START_IN_CMD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> ((state_q == S_ON_CMD) || (state_q == S_OFF_CMD))); // R13

    AST_RST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_rst) |-> (supply_on && panel_en)); // R3

    AST_PWR_DN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_on) |-> (!panel_en && panel_rst)); // R5

    AST_BL_ON_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_en) |-> (state_q == S_BL_ON)); // R6

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_prepare,
    input  logic             req_unprepare,
    input  logic             req_enable,
    input  logic             req_disable,
    input  logic [DLY_W-1:0] dly_prepare,
    input  logic [DLY_W-1:0] dly_reset,
    input  logic [DLY_W-1:0] dly_init,
    input  logic [DLY_W-1:0] dly_unprepare,
    input  logic [DLY_W-1:0] dly_enable,
    input  logic [DLY_W-1:0] dly_disable,
    input  logic             supply_invert,
    input  logic             ms_tick,
    input  logic             cmd_done,
    output logic             supply_en,
    output logic             panel_en,
    output logic             panel_rst,
    output logic             bl_en,
    output logic             cmd_start,
    output logic             cmd_sel,
    output logic             busy
);

    pps_state_e       state_q;
    pps_state_e       state_d;
    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    logic             tmr_last;
    logic             supply_on;

    pps_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_prepare   (req_prepare),
        .req_unprepare (req_unprepare),
        .req_enable    (req_enable),
        .req_disable   (req_disable),
        .dly_prepare   (dly_prepare),
        .dly_reset     (dly_reset),
        .dly_init      (dly_init),
        .dly_unprepare (dly_unprepare),
        .dly_enable    (dly_enable),
        .dly_disable   (dly_disable),
        .tmr_last      (tmr_last),
        .cmd_done      (cmd_done),
        .state_q       (state_q),
        .state_d       (state_d),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .busy          (busy)
    );

    pps_timer #(.W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (ms_tick),
        .last     (tmr_last)
    );

    pps_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .state_d   (state_d),
        .supply_on (supply_on),
        .panel_en  (panel_en),
        .panel_rst (panel_rst),
        .bl_en     (bl_en),
        .cmd_start (cmd_start),
        .cmd_sel   (cmd_sel)
    );

    assign supply_en = supply_on ^ supply_invert;

    AST_IDLE_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(panel_en) && $stable(bl_en))); // R7

endmodule

// File: tb/panel_pwr_seq_test.sv
module panel_pwr_seq_test;

    localparam int OP_P = 0, OP_U = 1, OP_E = 2, OP_D = 3;

    function automatic logic [32:0] mk(int op, int d0, int d1, int d2, bit inv, bit act,
                                       bit s, bit p, bit r, bit b);
        logic [2:0] o;
        logic [7:0] a, c, e;
        o = 3'(op); a = 8'(d0); c = 8'(d1); e = 8'(d2);
        return {o, a, c, e, inv, act, s, p, r, b};
    endfunction

    // op, d0, d1, d2, invert, accepted, supply_on, panel_en, panel_rst, bl_en
    localparam logic [32:0] VEC [14] = '{
        mk(OP_P, 3, 2, 4, 0, 1, 1, 1, 0, 0),
        mk(OP_P, 1, 1, 1, 0, 0, 1, 1, 0, 0),
        mk(OP_E, 5, 0, 0, 0, 1, 1, 1, 0, 1),
        mk(OP_E, 2, 0, 0, 0, 0, 1, 1, 0, 1),
        mk(OP_D, 2, 0, 0, 0, 1, 1, 1, 0, 0),
        mk(OP_U, 3, 0, 0, 0, 1, 0, 0, 1, 0),
        mk(OP_U, 1, 0, 0, 0, 0, 0, 0, 1, 0),
        mk(OP_D, 1, 0, 0, 0, 0, 0, 0, 1, 0),
        mk(OP_P, 0, 0, 0, 0, 1, 1, 1, 0, 0),
        mk(OP_E, 0, 0, 0, 0, 1, 1, 1, 0, 1),
        mk(OP_D, 0, 0, 0, 0, 1, 1, 1, 0, 0),
        mk(OP_U, 0, 0, 0, 0, 1, 0, 0, 1, 0),
        mk(OP_P, 2, 1, 1, 1, 1, 1, 1, 0, 0),
        mk(OP_U, 1, 0, 0, 1, 1, 0, 0, 1, 0)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_prepare = 0, req_unprepare = 0, req_enable = 0, req_disable = 0;
    logic [7:0] dly_prepare = 0, dly_reset = 0, dly_init = 0;
    logic [7:0] dly_unprepare = 0, dly_enable = 0, dly_disable = 0;
    logic supply_invert = 0, ms_tick = 1;
    logic resp_done = 0, stray_done = 0;
    logic cmd_done;
    logic supply_en, panel_en, panel_rst, bl_en, cmd_start, cmd_sel, busy;

    assign cmd_done = resp_done | stray_done;

    always #10 clk = ~clk;

    panel_pwr_seq #(.DLY_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_prepare(req_prepare), .req_unprepare(req_unprepare),
        .req_enable(req_enable), .req_disable(req_disable),
        .dly_prepare(dly_prepare), .dly_reset(dly_reset), .dly_init(dly_init),
        .dly_unprepare(dly_unprepare), .dly_enable(dly_enable), .dly_disable(dly_disable),
        .supply_invert(supply_invert), .ms_tick(ms_tick), .cmd_done(cmd_done),
        .supply_en(supply_en), .panel_en(panel_en), .panel_rst(panel_rst),
        .bl_en(bl_en), .cmd_start(cmd_start), .cmd_sel(cmd_sel), .busy(busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // edge stamps, written only by the monitor
    int t_pen_r = -1, t_pen_f = -1, t_rst_r = -1, t_rst_f = -1, t_sup = -1;
    int t_bl_r = -1, t_bl_f = -1, t_busy_r = -1, t_busy_f = -1, t_start = -1;
    int n_start = 0;
    logic sel_last = 0;
    logic p_pen = 0, p_rst = 0, p_bl = 0, p_busy = 0, p_sup = 0;

    always @(negedge clk) begin
        if (panel_en && !p_pen) t_pen_r = cyc;
        if (!panel_en && p_pen) t_pen_f = cyc;
        if (panel_rst && !p_rst) t_rst_r = cyc;
        if (!panel_rst && p_rst) t_rst_f = cyc;
        if ((supply_en ^ supply_invert) != p_sup) t_sup = cyc;
        if (bl_en && !p_bl) t_bl_r = cyc;
        if (!bl_en && p_bl) t_bl_f = cyc;
        if (busy && !p_busy) t_busy_r = cyc;
        if (!busy && p_busy) t_busy_f = cyc;
        if (cmd_start) begin
            n_start++;
            t_start = cyc;
            sel_last = cmd_sel;
        end
        p_pen = panel_en; p_rst = panel_rst; p_bl = bl_en; p_busy = busy;
        p_sup = supply_en ^ supply_invert;
    end

    // command-stream engine model: done three cycles after start
    int t_done = -1;
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_start) begin
                repeat (3) @(negedge clk);
                resp_done = 1'b1;
                t_done = cyc;
                @(negedge clk);
                resp_done = 1'b0;
            end
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic pulse(int op);
        @(negedge clk);
        case (op)
            OP_P: req_prepare = 1'b1;
            OP_U: req_unprepare = 1'b1;
            OP_E: req_enable = 1'b1;
            default: req_disable = 1'b1;
        endcase
        @(negedge clk);
        req_prepare = 0; req_unprepare = 0; req_enable = 0; req_disable = 0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        repeat (2) @(negedge clk);
        while (busy && guard < 600) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(logic [32:0] v);
        int op, d0, d1, d2, base, s0;
        bit act;
        op = int'(v[32:30]); d0 = int'(v[29:22]); d1 = int'(v[21:14]); d2 = int'(v[13:6]);
        act = v[4];
        dly_prepare = 8'(d0); dly_reset = 8'(d1); dly_init = 8'(d2);
        dly_unprepare = 8'(d0); dly_enable = 8'(d0); dly_disable = 8'(d0);
        supply_invert = v[5];
        ms_tick = 1'b1;
        @(negedge clk);
        base = cyc;
        s0 = n_start;
        pulse(op);
        wait_idle();
        if (!act) begin
            chk("R7", "ignored request raised busy", int'(t_busy_r > base), 0);
        end else begin
            case (op)
                OP_P: begin
                    chk("R2", "panel_en rise vs busy rise", t_pen_r, t_busy_r);
                    chk("R2", "supply change vs busy rise", t_sup, t_busy_r);
                    if (t_rst_r > base)
                        chk("R2", "reset rise gap", t_rst_r - t_pen_r, 1 + d0);
                    chk("R3", "reset fall gap", t_rst_f - t_pen_r, 2 + d0 + d1);
                    chk("R3", "start gap after reset fall", t_start - t_rst_f, 1 + d2);
                    chk("R3", "stream select", int'(sel_last), 0);
                    chk("R13", "start pulse count", n_start - s0, 1);
                    chk("R4", "busy fall after done", t_busy_f, t_done + 1);
                    if (d0 == 0 && d1 == 0 && d2 == 0)
                        chk("R8", "zero-delay start gap", t_start - t_pen_r, 3);
                end
                OP_U: begin
                    chk("R5", "off start with busy", t_start, t_busy_r);
                    chk("R5", "stream select", int'(sel_last), 1);
                    chk("R13", "start pulse count", n_start - s0, 1);
                    chk("R5", "panel_en fall after done", t_pen_f, t_done + 1);
                    chk("R5", "supply off after done", t_sup, t_done + 1);
                    chk("R5", "busy tail", t_busy_f - t_pen_f, 1 + d0);
                end
                OP_E: begin
                    chk("R6", "backlight on gap", t_bl_r - t_busy_r, d0);
                    chk("R6", "busy fall after backlight", t_busy_f, t_bl_r + 1);
                end
                default: begin
                    chk("R6", "backlight off with busy", t_bl_f, t_busy_r);
                    chk("R6", "busy tail", t_busy_f - t_bl_f, 1 + d0);
                end
            endcase
        end
        chk("R10", "supply_en", int'(supply_en), int'(v[3] ^ v[5]));
        chk("R7", "panel_en", int'(panel_en), int'(v[2]));
        chk("R7", "panel_rst", int'(panel_rst), int'(v[1]));
        chk("R7", "bl_en", int'(bl_en), int'(v[0]));
        chk("R4", "busy idle", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "supply_en", int'(supply_en), 0);
        chk("R1", "panel_en", int'(panel_en), 0);
        chk("R1", "panel_rst", int'(panel_rst), 0);
        chk("R1", "bl_en", int'(bl_en), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "cmd_start", int'(cmd_start), 0);

        for (int i = 0; i < 14; i++) run_vec(VEC[i]);

        // R9 and R11: stalled tick mid-prepare, enable arriving while busy
        supply_invert = 0;
        dly_prepare = 4; dly_reset = 1; dly_init = 1; dly_enable = 0;
        ms_tick = 1'b0;
        s0 = n_start;
        pulse(OP_P);
        repeat (20) @(negedge clk);
        chk("R11", "busy while tick low", int'(busy), 1);
        chk("R11", "reset not released", int'(panel_rst), 1);
        chk("R11", "no start while stalled", n_start - s0, 0);
        pulse(OP_E);
        ms_tick = 1'b1;
        wait_idle();
        chk("R9", "enable during busy dropped", int'(bl_en), 0);
        chk("R9", "prepare completed", int'(panel_rst), 0);
        chk("R9", "supply on", int'(supply_en), 1);

        // R12: enable, then disable and unprepare together
        pulse(OP_E);
        wait_idle();
        chk("R12", "backlight on before test", int'(bl_en), 1);
        @(negedge clk);
        req_disable = 1'b1; req_unprepare = 1'b1;
        @(negedge clk);
        req_disable = 1'b0; req_unprepare = 1'b0;
        wait_idle();
        chk("R12", "disable won: backlight", int'(bl_en), 0);
        chk("R12", "unprepare dropped: panel_en", int'(panel_en), 1);
        chk("R12", "unprepare dropped: supply", int'(supply_en), 1);

        // R13: stray done while idle
        s0 = n_start;
        @(negedge clk);
        stray_done = 1'b1;
        @(negedge clk);
        stray_done = 1'b0;
        repeat (5) @(negedge clk);
        chk("R13", "stray done busy", int'(busy), 0);
        chk("R13", "stray done panel_en", int'(panel_en), 1);
        chk("R13", "stray done start", n_start - s0, 0);

        finish_run();
    end

endmodule